// File: doc/BRIEF.md
# Security-gated coprocessor permission register bank

This block keeps three system-control registers and enforces the rules between them. A gate register sets what non-secure software may do. The two registers it governs are a coprocessor permission register and an auxiliary control register. One register port serves all accesses. Each access carries a valid strobe, a read/write flag, a 2-bit register select, 32-bit write data and a flag that marks the access as non-secure.

Depending on the security state of the access, a field of a governed register may be writable, may ignore the write, or may read as 1 whatever was stored. Some non-secure accesses are refused outright. A refused access raises a one-cycle undefined-instruction trap and changes no state.

The bank exports decoded permission levels for the rest of the core:
- non-secure use of coprocessors 10 and 11;
- allocation of lockable translation entries;
- access to the preload-engine register group;
- the SIMD disable and the upper-register-bank disable as seen in non-secure state;
- the coherency-participation (SMP) bit.

Register select encoding: 0 is the gate register, 1 is the coprocessor permission register, 2 is the auxiliary register and 3 is the preload-engine register group. The bank stores nothing for the preload-engine group; it only decides whether an access to it traps.

Top module: `cpctl_bank`

## Requirements
- R1: After synchronous reset, all three registers hold zero and every permission output is 0. `trap` is 0 and `rd_data` is 0.
- R2: The gate register stores only bits 18, 17, 16, 15, 14, 11 and 10. All other bits read as 0. A secure write of all ones therefore reads back 0x0007CC00 (bit 16 is also 0 when the preload engine is absent).
- R3: A non-secure write to the gate register traps and leaves the register unchanged. A non-secure read of the gate register returns its value without a trap.
- R4: While gate bit 18 is 0, a non-secure write to the auxiliary register traps and leaves the whole register, including the SMP bit (bit 6), unchanged.
- R5: While gate bit 18 is 1, a non-secure write to the auxiliary register updates only bit 6 and does not trap. A secure write updates all eight stored bits [7:0].
- R6: The permission outputs follow the gate bits: `cp10_ns_ok` follows bit 10, `cp11_ns_ok` bit 11, `tlb_lock_ns_ok` bit 17 and `pld_ns_ok` bit 16. `smp_en` follows auxiliary bit 6.
- R7: Any non-secure access to select 3 traps while gate bit 16 is 0, and does not trap while it is 1. Secure accesses to select 3 never trap. Reads of select 3 return 0.
- R8: While gate bit 15 is 1, the SIMD-disable bit (bit 31) of the coprocessor permission register reads as 1 for non-secure reads, and non-secure writes leave it unchanged. A secure read returns the stored bit. `simd_off_ns` is the stored bit OR gate bit 15.
- R9: Gate bit 14 controls the upper-register-bank disable bit (bit 30) of the coprocessor permission register, with the same behaviour as R8. `hireg_off_ns` is the stored bit OR gate bit 14.
- R10: `trap` is high for exactly the one cycle after a refused access, and `rd_data` is updated in the cycle after an accepted read. The coprocessor permission register stores only bits 31, 30 and [23:20].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Register select (0 gate, 1 coprocessor permission, 2 auxiliary, 3 preload group) |
| acc_wdata | input | 32 | Write data |
| acc_nonsec | input | 1 | 1 = access made in non-secure state |
| rd_data | output | 32 | Registered read data |
| trap | output | 1 | Undefined-instruction trap pulse |
| cp10_ns_ok | output | 1 | Non-secure use of coprocessor 10 allowed |
| cp11_ns_ok | output | 1 | Non-secure use of coprocessor 11 allowed |
| tlb_lock_ns_ok | output | 1 | Non-secure allocation of lockable translation entries allowed |
| pld_ns_ok | output | 1 | Non-secure preload-engine access allowed |
| simd_off_ns | output | 1 | Effective SIMD disable in non-secure state |
| hireg_off_ns | output | 1 | Effective upper-register-bank disable in non-secure state |
| smp_en | output | 1 | Coherency participation bit |

## Verification
Directed sequences cover every gate bit in both states and each select under both security flags. Each refused case is paired with its accepted counterpart, so that a wrongly decoded trap condition shows up as a trap that is missing or present when it should not be. Secure and non-secure reads of the same forced bit are compared. This separates a force that wrongly changes the stored value from one applied on the read path only. Random accesses with random data and security flags then run against a bench model, which also checks that masked and reserved bits never leak into reads.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;
  typedef enum logic [1:0] {
    SEL_GATE = 2'd0,
    SEL_CPA  = 2'd1,
    SEL_AUX  = 2'd2,
    SEL_PLD  = 2'd3
  } sel_e;

  // gate register field positions (decoded by neighbours)
  localparam int G_AUXWR = 18;
  localparam int G_TLB   = 17;
  localparam int G_PLD   = 16;
  localparam int G_SIMD  = 15;
  localparam int G_HIREG = 14;
  localparam int G_CP11  = 11;
  localparam int G_CP10  = 10;

  // coprocessor permission register forced fields
  localparam int C_SIMD  = 31;
  localparam int C_HIREG = 30;

  function automatic logic [31:0] gate_mask(input bit has_pld);
    logic [31:0] m;
    m = '0;
    m[G_AUXWR] = 1'b1;
    m[G_TLB]   = 1'b1;
    m[G_PLD]   = has_pld;
    m[G_SIMD]  = 1'b1;
    m[G_HIREG] = 1'b1;
    m[G_CP11]  = 1'b1;
    m[G_CP10]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cpctl_decode.sv
module cpctl_decode
  import cpctl_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             acc_nonsec,
  input  logic             gate_auxwr,
  input  logic             gate_pld,
  output logic             trap_now,
  output logic             we_gate,
  output logic             we_cpa,
  output logic             we_aux_all,
  output logic             we_aux_smp,
  output logic             rd_now
);
  logic is_w;
  logic hit_gate, hit_cpa, hit_aux, hit_pld;

  always_comb begin
    hit_gate = (acc_sel == SEL_GATE);
    hit_cpa  = (acc_sel == SEL_CPA);
    hit_aux  = (acc_sel == SEL_AUX);
    hit_pld  = (acc_sel == SEL_PLD);
    is_w     = acc_valid & acc_write;
    trap_now = acc_valid & acc_nonsec &
               ((acc_write & hit_gate) |
                (acc_write & hit_aux & ~gate_auxwr) |
                (hit_pld & ~gate_pld));
    we_gate    = is_w & ~acc_nonsec & hit_gate;
    we_cpa     = is_w & hit_cpa;
    we_aux_all = is_w & ~acc_nonsec & hit_aux;
    we_aux_smp = is_w & acc_nonsec & hit_aux & gate_auxwr;
    rd_now     = acc_valid & ~acc_write & ~trap_now;
  end

  // R7
  secure_never_traps_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_nonsec) |-> !trap_now);
endmodule

// File: rtl/cpctl_regs.sv
module cpctl_regs
  import cpctl_pkg::*;
#(
  parameter int          DW       = 32,
  parameter bit          HAS_PLE  = 1'b1,
  parameter logic [31:0] CPA_MASK = 32'hC0F0_0000,
  parameter logic [31:0] AUX_MASK = 32'h0000_00FF,
  parameter int          SMP_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_gate,
  input  logic          we_cpa,
  input  logic          we_aux_all,
  input  logic          we_aux_smp,
  input  logic          acc_nonsec,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gate_q,
  output logic [DW-1:0] cpa_q,
  output logic [DW-1:0] aux_q
);
  localparam logic [DW-1:0] GMASK = DW'(gate_mask(HAS_PLE));
  localparam logic [DW-1:0] CMASK = DW'(CPA_MASK);
  localparam logic [DW-1:0] AMASK = DW'(AUX_MASK);

  logic [DW-1:0] cpa_keep;

  always_comb begin
    cpa_keep = '0;
    if (acc_nonsec) begin
      cpa_keep[C_SIMD]  = gate_q[G_SIMD];
      cpa_keep[C_HIREG] = gate_q[G_HIREG];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      cpa_q  <= '0;
      aux_q  <= '0;
    end else begin
      if (we_gate) gate_q <= wdata & GMASK;
      if (we_cpa)  cpa_q  <= (wdata & CMASK & ~cpa_keep) | (cpa_q & cpa_keep);
      if (we_aux_all)      aux_q          <= wdata & AMASK;
      else if (we_aux_smp) aux_q[SMP_BIT] <= wdata[SMP_BIT];
    end
  end

  // R4
  aux_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_aux_all && !we_aux_smp) |=> $stable(aux_q));

  // R5
  aux_ns_smp_only_chk: assert property (@(posedge clk) disable iff (rst)
    we_aux_smp |=> (((aux_q ^ $past(aux_q)) & ~(DW'(1) << SMP_BIT)) == '0));

  // R8
  simd_ns_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we_cpa && acc_nonsec && gate_q[G_SIMD]) |=> $stable(cpa_q[C_SIMD]));

  // R9
  hireg_ns_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we_cpa && acc_nonsec && gate_q[G_HIREG]) |=> $stable(cpa_q[C_HIREG]));
endmodule

// File: rtl/cpctl_rdport.sv
module cpctl_rdport
  import cpctl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_now,
  input  logic             trap_now,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             acc_nonsec,
  input  logic [DW-1:0]    gate_q,
  input  logic [DW-1:0]    cpa_q,
  input  logic [DW-1:0]    aux_q,
  output logic [DW-1:0]    rd_data,
  output logic             trap
);
  logic [DW-1:0] cpa_force;
  logic [DW-1:0] rd_mux;

  always_comb begin
    cpa_force = '0;
    if (acc_nonsec) begin
      cpa_force[C_SIMD]  = gate_q[G_SIMD];
      cpa_force[C_HIREG] = gate_q[G_HIREG];
    end
    unique case (acc_sel)
      SEL_GATE: rd_mux = gate_q;
      SEL_CPA:  rd_mux = cpa_q | cpa_force;
      SEL_AUX:  rd_mux = aux_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      trap    <= 1'b0;
    end else begin
      trap <= trap_now;
      if (rd_now) rd_data <= rd_mux;
    end
  end

  // R8
  simd_ns_view_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_now && acc_nonsec && acc_sel == SEL_CPA && gate_q[G_SIMD]) |=> rd_data[C_SIMD]);
endmodule

// File: rtl/cpctl_bank.sv
module cpctl_bank
  import cpctl_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          SEL_W    = 2,
  parameter bit          HAS_PLE  = 1'b1,
  parameter logic [31:0] CPA_MASK = 32'hC0F0_0000,
  parameter logic [31:0] AUX_MASK = 32'h0000_00FF,
  parameter int          SMP_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [DW-1:0]    acc_wdata,
  input  logic             acc_nonsec,
  output logic [DW-1:0]    rd_data,
  output logic             trap,
  output logic             cp10_ns_ok,
  output logic             cp11_ns_ok,
  output logic             tlb_lock_ns_ok,
  output logic             pld_ns_ok,
  output logic             simd_off_ns,
  output logic             hireg_off_ns,
  output logic             smp_en
);
  logic [DW-1:0] gate_q, cpa_q, aux_q;
  logic trap_now, we_gate, we_cpa, we_aux_all, we_aux_smp, rd_now;

  cpctl_decode #(.SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_nonsec(acc_nonsec),
    .gate_auxwr(gate_q[G_AUXWR]), .gate_pld(gate_q[G_PLD]),
    .trap_now(trap_now), .we_gate(we_gate), .we_cpa(we_cpa),
    .we_aux_all(we_aux_all), .we_aux_smp(we_aux_smp), .rd_now(rd_now)
  );

  cpctl_regs #(
    .DW(DW), .HAS_PLE(HAS_PLE), .CPA_MASK(CPA_MASK),
    .AUX_MASK(AUX_MASK), .SMP_BIT(SMP_BIT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we_gate(we_gate), .we_cpa(we_cpa),
    .we_aux_all(we_aux_all), .we_aux_smp(we_aux_smp),
    .acc_nonsec(acc_nonsec), .wdata(acc_wdata),
    .gate_q(gate_q), .cpa_q(cpa_q), .aux_q(aux_q)
  );

  cpctl_rdport #(.DW(DW), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst),
    .rd_now(rd_now), .trap_now(trap_now),
    .acc_sel(acc_sel), .acc_nonsec(acc_nonsec),
    .gate_q(gate_q), .cpa_q(cpa_q), .aux_q(aux_q),
    .rd_data(rd_data), .trap(trap)
  );

  always_comb begin
    cp10_ns_ok     = gate_q[G_CP10];
    cp11_ns_ok     = gate_q[G_CP11];
    tlb_lock_ns_ok = gate_q[G_TLB];
    pld_ns_ok      = gate_q[G_PLD];
    simd_off_ns    = cpa_q[C_SIMD]  | gate_q[G_SIMD];
    hireg_off_ns   = cpa_q[C_HIREG] | gate_q[G_HIREG];
    smp_en         = aux_q[SMP_BIT];
  end

  // R10
  trap_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(acc_valid));

  // R3
  gate_ns_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_nonsec && acc_sel == SEL_GATE) |=> (trap && $stable(gate_q)));
endmodule

// File: tb/test_cpctl_bank.sv
module test_cpctl_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_nonsec = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic trap, cp10_ns_ok, cp11_ns_ok, tlb_lock_ns_ok, pld_ns_ok;
  logic simd_off_ns, hireg_off_ns, smp_en;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_gate = '0, m_cpa = '0, m_aux = '0;

  always #5 clk = ~clk;

  cpctl_bank i_cpctl_bank (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_nonsec(acc_nonsec),
    .rd_data(rd_data), .trap(trap), .cp10_ns_ok(cp10_ns_ok),
    .cp11_ns_ok(cp11_ns_ok), .tlb_lock_ns_ok(tlb_lock_ns_ok),
    .pld_ns_ok(pld_ns_ok), .simd_off_ns(simd_off_ns),
    .hireg_off_ns(hireg_off_ns), .smp_en(smp_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_trap(input logic w, input logic [1:0] s, input logic ns);
    return ns && ((w && s == 2'd0) || (w && s == 2'd2 && !m_gate[18]) ||
                  (s == 2'd3 && !m_gate[16]));
  endfunction

  function automatic logic [31:0] ns_force(input logic ns);
    return ns ? {m_gate[15], m_gate[14], 30'b0} : 32'b0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] s, input logic ns);
    case (s)
      2'd0: return m_gate;
      2'd1: return m_cpa | ns_force(ns);
      2'd2: return m_aux;
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_write(input logic [1:0] s, input logic ns, input logic [31:0] d);
    logic [31:0] keep;
    case (s)
      2'd0: m_gate = d & 32'h0007_CC00;
      2'd1: begin
        keep  = ns_force(ns);
        m_cpa = (d & 32'hC0F0_0000 & ~keep) | (m_cpa & keep);
      end
      2'd2: if (ns) m_aux[6] = d[6]; else m_aux = d & 32'h0000_00FF;
      default: ;
    endcase
  endtask

  task automatic chk_outputs();
    chk("R6 cp10", {31'b0, cp10_ns_ok}, {31'b0, m_gate[10]});
    chk("R6 cp11", {31'b0, cp11_ns_ok}, {31'b0, m_gate[11]});
    chk("R6 tlb",  {31'b0, tlb_lock_ns_ok}, {31'b0, m_gate[17]});
    chk("R6 pld",  {31'b0, pld_ns_ok}, {31'b0, m_gate[16]});
    chk("R6 smp",  {31'b0, smp_en}, {31'b0, m_aux[6]});
    chk("R8 simd_off_ns",  {31'b0, simd_off_ns},  {31'b0, m_cpa[31] | m_gate[15]});
    chk("R9 hireg_off_ns", {31'b0, hireg_off_ns}, {31'b0, m_cpa[30] | m_gate[14]});
  endtask

  task automatic do_op(input string tag, input logic w, input logic [1:0] s,
                       input logic ns, input logic [31:0] d);
    logic t;
    logic [31:0] r;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_sel = s; acc_nonsec = ns; acc_wdata = d;
    t = exp_trap(w, s, ns);
    r = exp_read(s, ns);
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " trap"}, {31'b0, trap}, {31'b0, t});
    if (!w && !t) chk({tag, " rd_data"}, rd_data, r);
    if (w && !t) model_write(s, ns, d);
    chk_outputs();
    @(negedge clk);
    chk("R10 trap pulse width", {31'b0, trap}, 32'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 32'b0);
    chk("R1 trap", {31'b0, trap}, 32'b0);
    chk_outputs();
    // R2 reserved bits
    do_op("R2", 1'b1, 2'd0, 1'b0, 32'hFFFF_FFFF);
    do_op("R2", 1'b0, 2'd0, 1'b0, 32'h0);
    chk("R2 value", rd_data, 32'h0007_CC00);
    // R3 non-secure gate write
    do_op("R3", 1'b1, 2'd0, 1'b1, 32'h0);
    do_op("R3", 1'b0, 2'd0, 1'b1, 32'h0);
    // R10 coprocessor register stored bits, secure reads see stored value
    do_op("R10", 1'b1, 2'd1, 1'b0, 32'h0000_0000);
    do_op("R8", 1'b0, 2'd1, 1'b1, 32'h0);
    chk("R8 forced ns read", rd_data, 32'hC000_0000);
    do_op("R8", 1'b0, 2'd1, 1'b0, 32'h0);
    chk("R8 secure read stored", rd_data, 32'h0);
    do_op("R9", 1'b1, 2'd1, 1'b1, 32'h0FFF_FFFF);
    do_op("R9", 1'b0, 2'd1, 1'b0, 32'h0);
    chk("R9 ns write kept forced bits", rd_data, 32'h00F0_0000);
    // R4 / R5 auxiliary
    do_op("R4", 1'b1, 2'd0, 1'b0, 32'h0000_0000);
    do_op("R4", 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF);
    do_op("R4", 1'b0, 2'd2, 1'b0, 32'h0);
    chk("R4 aux unchanged", rd_data, 32'h0);
    do_op("R5", 1'b1, 2'd0, 1'b0, 32'h0004_0000);
    do_op("R5", 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF);
    do_op("R5", 1'b0, 2'd2, 1'b1, 32'h0);
    chk("R5 only smp", rd_data, 32'h0000_0040);
    do_op("R5", 1'b1, 2'd2, 1'b0, 32'hFFFF_FF3C);
    // R7 preload group
    do_op("R7", 1'b0, 2'd3, 1'b1, 32'h0);
    do_op("R7", 1'b1, 2'd3, 1'b0, 32'h1234_5678);
    do_op("R7", 1'b1, 2'd0, 1'b0, 32'h0001_0000);
    do_op("R7", 1'b0, 2'd3, 1'b1, 32'h0);
    chk("R7 reads zero", rd_data, 32'h0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 8) == 0) d = 32'hFFFF_FFFF;
      do_op("RND", 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), d);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule